// File: doc/BRIEF.md
# Low-Rate Bypass Clock Enable Generator

This block produces the clock enables a chip runs on when its PLL is bypassed and everything is clocked from the reference input. The reference is divided by a power of two chosen by a 5-bit exponent, which gives a core clock enable. A bus clock enable is taken from every third core enable, so the core-to-bus ratio stays 3:1 for every divide setting. All logic runs on the reference clock.

Low-rate operation is chosen at reset from a boot configuration pin, and software can enter or leave it with a control bit. While it is active the block tells the PLL to bypass and power down, and holds a disable for the high-speed peripherals (the SDRAM and Ethernet controllers) that cannot run at such rates. The exponent can be rewritten at any time. A new value waits in a shadow register and takes over only when the current divided period ends, so no period is ever cut short. The PLL multiplier register accepts writes only while low-rate operation is active, because only then is the PLL out of the clock path.

Top module: `limp_clk_gen`

## Requirements
- R1: During synchronous reset (rst high) the mode is loaded from `boot_limp_i`, the active and shadow exponents are loaded from `RST_DIV`, the multiplier is loaded from `RST_MULT`, and the divided-period and bus-phase counts are set to zero.
- R2: While low-rate mode is active with exponent n (0..31), `core_en_o` is high for one reference cycle in every 2^n cycles, counted from the first cycle of the mode. With n = 0 it is high on every cycle.
- R3: `bus_en_o` is high only in a cycle where `core_en_o` is high. It fires on the third, sixth, ninth and so on core enable after low-rate mode is entered.
- R4: A write of `div_wdata_i` with `div_wr_i` goes to the shadow exponent. In low-rate mode it governs the period that starts after the next `core_en_o`, and a write in that same cycle already governs the next period. Outside low-rate mode it becomes active on the next cycle.
- R5: A write of `limp_wdata_i` with `limp_wr_i` sets the requested mode (1 = low-rate). From normal mode a request for low-rate takes effect on the following cycle.
- R6: Low-rate mode is left only in the cycle after a `bus_en_o` pulse, so both the core and the bus periods are complete. A pending exit request holds the mode until then.
- R7: `pll_bypass_o` and `hs_periph_dis_o` are high exactly while low-rate mode is active. `core_en_o` and `bus_en_o` are low in normal mode.
- R8: A write with `mult_wr_i` updates `mult_o` only when low-rate mode is active in that cycle. In normal mode the write is ignored and `mult_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference input clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_limp_i | input | 1 | Boot configuration: 1 selects low-rate mode at reset |
| limp_wr_i | input | 1 | Write strobe for the mode request bit |
| limp_wdata_i | input | 1 | Requested mode, 1 = low-rate |
| div_wr_i | input | 1 | Write strobe for the divide exponent |
| div_wdata_i | input | DIV_W | New divide exponent n |
| mult_wr_i | input | 1 | Write strobe for the PLL multiplier |
| mult_wdata_i | input | MULT_W | New PLL multiplier value |
| pll_bypass_o | output | 1 | PLL bypass and power-down select |
| core_en_o | output | 1 | Core clock enable |
| bus_en_o | output | 1 | Bus clock enable |
| hs_periph_dis_o | output | 1 | Disable for the SDRAM and Ethernet controllers |
| mult_o | output | MULT_W | Current PLL multiplier |

## Verification
On every cycle the assertions check four things. The divided count never passes its period end. The active exponent holds inside a period. A bus enable never comes without a core enable. The mode never drops except right after a bus enable, and the multiplier never moves in normal mode. How the pulses are spaced for each exponent, the 3:1 counting from mode entry, where a mid-period rewrite lands, and what reset does in each boot setting can only be shown by the bench's scenarios, which compare every cycle against a behavioural model.

// File: rtl/limp_clk_pkg.sv
package limp_clk_pkg;
  localparam int unsigned CNT_W = 32;
  localparam int unsigned BUS_RATIO = 3;

  // last count value of a 2^n period
  function automatic logic [CNT_W-1:0] period_last(input logic [4:0] n);
    period_last = (CNT_W'(1) << n) - CNT_W'(1);
  endfunction
endpackage

// File: rtl/limp_divider.sv
module limp_divider
  import limp_clk_pkg::*;
#(
  parameter int unsigned DIV_W = 5,
  parameter logic [DIV_W-1:0] RST_DIV = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  output logic             core_en
);
  logic [DIV_W-1:0] shadow_q, act_q, shadow_nxt;
  logic [CNT_W-1:0] cnt_q, last_cnt;
  logic             prd_end;

  assign shadow_nxt = div_wr ? div_wdata : shadow_q;
  assign last_cnt   = period_last(5'(act_q));
  assign core_en    = run && (cnt_q == last_cnt);
  assign prd_end    = !run || core_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= RST_DIV;
      act_q    <= RST_DIV;
      cnt_q    <= '0;
    end else begin
      shadow_q <= shadow_nxt;
      if (prd_end) act_q <= shadow_nxt;
      if (!run || core_en) cnt_q <= '0;
      else cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_cnt);
  // R4
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !core_en) |=> $stable(act_q));
endmodule

// File: rtl/limp_ratio.sv
module limp_ratio
  import limp_clk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic core_en,
  output logic bus_en
);
  localparam int unsigned PH_W = $clog2(BUS_RATIO);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BUS_RATIO - 1);
  logic [PH_W-1:0] ph_q;

  assign bus_en = core_en && (ph_q == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) ph_q <= '0;
    else if (core_en) ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
  end

  // R3
  ph_range_chk: assert property (@(posedge clk) disable iff (rst)
    ph_q <= PH_LAST);
endmodule

// File: rtl/limp_mode_ctl.sv
module limp_mode_ctl #(
  parameter int unsigned MULT_W = 8,
  parameter logic [MULT_W-1:0] RST_MULT = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_limp,
  input  logic              limp_wr,
  input  logic              limp_wdata,
  input  logic              bnd_ok,
  input  logic              mult_wr,
  input  logic [MULT_W-1:0] mult_wdata,
  output logic              limp,
  output logic [MULT_W-1:0] mult
);
  logic req_q, req_nxt, switch_ok;

  assign req_nxt   = limp_wr ? limp_wdata : req_q;
  assign switch_ok = !limp || bnd_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= boot_limp;
      limp  <= boot_limp;
      mult  <= RST_MULT;
    end else begin
      req_q <= req_nxt;
      if (switch_ok) limp <= req_nxt;
      if (limp && mult_wr) mult <= mult_wdata;
    end
  end

  // R6
  exit_at_bnd_chk: assert property (@(posedge clk) disable iff (rst)
    (limp && !bnd_ok) |=> limp);
  // R8
  mult_locked_chk: assert property (@(posedge clk) disable iff (rst)
    !limp |=> $stable(mult));
endmodule

// File: rtl/limp_clk_gen.sv
module limp_clk_gen #(
  parameter int unsigned DIV_W = 5,
  parameter int unsigned MULT_W = 8,
  parameter logic [DIV_W-1:0] RST_DIV = 3,
  parameter logic [MULT_W-1:0] RST_MULT = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_limp_i,
  input  logic              limp_wr_i,
  input  logic              limp_wdata_i,
  input  logic              div_wr_i,
  input  logic [DIV_W-1:0]  div_wdata_i,
  input  logic              mult_wr_i,
  input  logic [MULT_W-1:0] mult_wdata_i,
  output logic              pll_bypass_o,
  output logic              core_en_o,
  output logic              bus_en_o,
  output logic              hs_periph_dis_o,
  output logic [MULT_W-1:0] mult_o
);
  logic limp_act, core_tick, bus_tick;

  limp_mode_ctl #(.MULT_W(MULT_W), .RST_MULT(RST_MULT)) u_mode (
    .clk(clk), .rst(rst), .boot_limp(boot_limp_i),
    .limp_wr(limp_wr_i), .limp_wdata(limp_wdata_i), .bnd_ok(bus_tick),
    .mult_wr(mult_wr_i), .mult_wdata(mult_wdata_i),
    .limp(limp_act), .mult(mult_o)
  );

  limp_divider #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_div (
    .clk(clk), .rst(rst), .run(limp_act),
    .div_wr(div_wr_i), .div_wdata(div_wdata_i), .core_en(core_tick)
  );

  limp_ratio u_ratio (
    .clk(clk), .rst(rst), .run(limp_act),
    .core_en(core_tick), .bus_en(bus_tick)
  );

  assign pll_bypass_o    = limp_act;
  assign hs_periph_dis_o = limp_act;
  assign core_en_o       = core_tick;
  assign bus_en_o        = bus_tick;

  // R3
  bus_needs_core_chk: assert property (@(posedge clk) disable iff (rst)
    bus_tick |-> core_tick);
  // R7
  core_only_limp_chk: assert property (@(posedge clk) disable iff (rst)
    core_tick |-> limp_act);
endmodule

// File: tb/limp_clk_gen_bench.sv
module limp_clk_gen_bench;
  localparam int unsigned DIV_W = 5;
  localparam int unsigned MULT_W = 8;
  localparam logic [DIV_W-1:0] RST_DIV = 3;
  localparam logic [MULT_W-1:0] RST_MULT = 27;

  logic clk = 1'b0;
  logic rst = 1'b1, boot = 1'b0;
  logic limp_wr = 0, limp_d = 0, div_wr = 0, mult_wr = 0;
  logic [DIV_W-1:0] div_d = '0;
  logic [MULT_W-1:0] mult_d = '0;
  logic byp, core, bus, hsd;
  logic [MULT_W-1:0] mult;

  int errors = 0, checks = 0, cycles = 0;
  string tag = "R1";
  int m_limp, m_req, m_sh, m_act, m_ph, m_mult;
  longint m_cnt;
  int core_cnt, bus_cnt;

  always #4 clk = ~clk;

  limp_clk_gen #(.DIV_W(DIV_W), .MULT_W(MULT_W), .RST_DIV(RST_DIV), .RST_MULT(RST_MULT))
  u_limp_clk_gen (
    .clk(clk), .rst(rst), .boot_limp_i(boot), .limp_wr_i(limp_wr),
    .limp_wdata_i(limp_d), .div_wr_i(div_wr), .div_wdata_i(div_d),
    .mult_wr_i(mult_wr), .mult_wdata_i(mult_d), .pll_bypass_o(byp),
    .core_en_o(core), .bus_en_o(bus), .hs_periph_dis_o(hsd), .mult_o(mult)
  );

  function automatic bit m_core();
    return (m_limp != 0) && (m_cnt == (longint'(1) << m_act) - 1);
  endfunction

  function automatic bit m_bus();
    return m_core() && (m_ph == 2);
  endfunction

  task automatic model_step();
    bit c, b;
    int nsh, nreq;
    if (rst) begin
      m_limp = boot; m_req = boot; m_sh = RST_DIV; m_act = RST_DIV;
      m_cnt = 0; m_ph = 0; m_mult = RST_MULT;
    end else begin
      c = m_core(); b = m_bus();
      nsh = div_wr ? int'(div_d) : m_sh;
      nreq = limp_wr ? int'(limp_d) : m_req;
      if (m_limp != 0 && mult_wr) m_mult = mult_d;
      if (m_limp == 0 || c) m_act = nsh;
      m_sh = nsh; m_req = nreq;
      if (m_limp != 0) begin
        if (c) begin m_cnt = 0; m_ph = (m_ph + 1) % 3; end
        else m_cnt = m_cnt + 1;
      end else begin
        m_cnt = 0; m_ph = 0;
      end
      if (m_limp == 0 || b) m_limp = nreq;
    end
  endtask

  task automatic compare();
    logic [MULT_W+3:0] exp_v, act_v;
    exp_v = {1'(m_limp), 1'(m_limp), m_core(), m_bus(), MULT_W'(m_mult)};
    act_v = {byp, hsd, core, bus, mult};
    checks++;
    if (exp_v !== act_v) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cycles, act_v, exp_v);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      cycles++;
      @(negedge clk);
      compare();
      if (core) core_cnt++;
      if (bus) bus_cnt++;
      limp_wr = 0; div_wr = 0; mult_wr = 0;
    end
  endtask

  task automatic named(string t, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", t, actual, expected);
    end
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R1"; rst = 1; boot = 0;
    cyc(2);
    rst = 0;
    cyc(5);
    named("R1 normal boot bypass", int'(byp), 0);
    named("R7 normal enables", int'(core | bus), 0);

    tag = "R8"; mult_wr = 1; mult_d = 8'h55;
    cyc(3);
    named("R8 mult ignored in normal", int'(mult), int'(RST_MULT));

    tag = "R4"; div_wr = 1; div_d = 0;
    cyc(1);
    tag = "R5"; limp_wr = 1; limp_d = 1;
    cyc(1);
    named("R5 limp entered", int'(byp), 1);
    tag = "R2"; core_cnt = 0; bus_cnt = 0;
    cyc(12);
    named("R2 n=0 every cycle", core_cnt, 12);
    named("R3 bus every third", bus_cnt, 4);

    tag = "R8"; mult_wr = 1; mult_d = 8'h30;
    cyc(2);
    named("R8 mult taken in limp", int'(mult), 8'h30);

    tag = "R4"; div_wr = 1; div_d = 2;
    cyc(1);
    cyc(12);
    tag = "R2"; core_cnt = 0; bus_cnt = 0;
    cyc(24);
    named("R2 n=2 pulses", core_cnt, 6);
    named("R3 n=2 bus pulses", bus_cnt, 2);

    tag = "R4"; cyc(2);
    div_wr = 1; div_d = 4;
    cyc(80);
    div_wr = 1; div_d = 1;
    cyc(7);
    div_wr = 1; div_d = 3;
    cyc(60);

    tag = "R6"; limp_wr = 1; limp_d = 0;
    cyc(2);
    named("R6 exit waits for boundary", int'(byp), 1);
    cyc(60);
    named("R6 limp left", int'(byp), 0);
    named("R7 disable off", int'(hsd), 0);

    tag = "R1"; boot = 1; rst = 1;
    cyc(2);
    rst = 0;
    named("R1 boot limp", int'(byp), 1);
    core_cnt = 0;
    cyc(64);
    named("R1 reset divider n=3", core_cnt, 8);
    cyc(20);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule